// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block gathers 32 main interrupt sources and a secondary bank of sub-sources into two request lines toward a processor: a normal interrupt request and a fast interrupt request. Each source has a pending bit that latches an event and a mask bit that decides whether the event may reach the processor. Sub-sources have their own pending and mask bank. Sub-sources that share a peripheral are OR-combined onto one main line.

Out of all main sources that are pending, enabled and not routed to the fast line, one winner is chosen: the one with the lowest number. It is held as a one-hot value in a separate register and drives the normal request. A mode register can steer a single source to the fast line. Software reads and writes the registers through a simple single-cycle port. It acknowledges a source by writing the same one-hot value first to the main pending register and then to the winner register.

Top module: `intc2lvl_top`

## Requirements
- R1: After reset all pending registers and the winner register read 0, the main mask reads all ones, the sub mask reads all ones over its SUB_CNT bits, the mode register reads 0, and both request outputs are low.
- R2: A mask bit of 1 blocks its source and a mask bit of 0 enables it. A masked main source is still recorded as pending, but it never becomes the winner and never drives the fast line.
- R3: An edge-type source sets its pending bit on a 0-to-1 change of its input. A level-type source sets its pending bit in every cycle its input is high, so clearing the bit while the input stays high has no lasting effect. On the main bank, sources 4, 5, 15, 23, 28 and 31 are level-type. On the sub bank, sources 0 to 8 are level-type and sources 9 and 10 are edge-type.
- R4: Writing a 1 to a bit of the main pending (byte offset 0x00), winner (0x10) or sub pending (0x18) register clears that bit. Writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R5: Main slots 6 and 24 are reserved and never become pending.
- R6: Sub-sources 0 to 2 feed main line 28, sub-sources 3 to 5 feed line 23, sub-sources 6 to 8 feed line 15, and sub-sources 9 and 10 feed line 31. A grouped line becomes pending while any of its sub-sources is pending with its sub mask bit at 0. The external pin of a grouped line is ignored.
- R7: The winner register holds at most one set bit. It loads only when it is empty, taking the lowest-numbered main source that is pending, unmasked and not selected by the mode register. While it is nonzero it keeps its value until its bit is written with 1.
- R8: The normal request output is high exactly while the winner register is nonzero.
- R9: The mode register (0x04) keeps only the lowest set bit of a written value. The fast request output is high while the selected source is pending and unmasked. Writing 0 returns every source to normal routing.
- R10: The registers sit at byte offsets 0x00 main pending, 0x04 mode, 0x08 main mask, 0x10 winner, 0x18 sub pending and 0x1C sub mask. Every other offset reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_main | input | 32 | Main source inputs |
| src_sub | input | SUB_CNT | Sub-source inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions check the following on every cycle:
- the winner and mode registers stay one-hot or empty;
- the normal request follows the winner;
- the reserved slots stay clear;
- a nonzero winner holds until it is written;
- an enabled pending sub-source forces its parent line pending;
- the fast line never rises without a mode selection;
- the state just after reset is correct.

Other behaviour needs the bench's scenarios. The sweeps cover the capture of every main slot and every sub-source's parent mapping. The scenarios also show:
- the difference between edge and level capture under a clear;
- lowest-number selection and the hand-over to the next winner after an acknowledge;
- the change of routing when the mode register is written.

// File: rtl/intc2lvl_pkg.sv
// Shared constants and helpers for the two-level interrupt controller.
// Assumes byte offsets on a 5-bit register address and at most 32 sources per bank.
package intc2lvl_pkg;

    localparam int REG_AW    = 5;
    localparam int NO_PARENT = 255;

    localparam logic [REG_AW-1:0] OFS_PEND  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_MODE  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_MASK  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_WIN   = 5'h10;
    localparam logic [REG_AW-1:0] OFS_SPEND = 5'h18;
    localparam logic [REG_AW-1:0] OFS_SMASK = 5'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MODE,
        SEL_MASK,
        SEL_WIN,
        SEL_SPEND,
        SEL_SMASK
    } reg_sel_e;

    // Map a byte offset onto a register selector.
    function automatic reg_sel_e decode_sel(input logic [REG_AW-1:0] a);
        case (a)
            OFS_PEND:  return SEL_PEND;
            OFS_MODE:  return SEL_MODE;
            OFS_MASK:  return SEL_MASK;
            OFS_WIN:   return SEL_WIN;
            OFS_SPEND: return SEL_SPEND;
            OFS_SMASK: return SEL_SMASK;
            default:   return SEL_NONE;
        endcase
    endfunction

    // Main line that a sub-source feeds, or NO_PARENT.
    function automatic int parent_of(input int s);
        if (s < 3)  return 28;
        if (s < 6)  return 23;
        if (s < 9)  return 15;
        if (s < 11) return 31;
        return NO_PARENT;
    endfunction

endpackage

// File: rtl/intc2lvl_pend_bank.sv
// Pending-bit bank: captures edge or level events per bit, write-one-to-clear.
// Assumes LEVEL_MASK and BLOCK_MASK are constant. A set in the same cycle as a clear wins.
module intc2lvl_pend_bank #(
    parameter int           W          = 32,
    parameter logic [W-1:0] LEVEL_MASK = '0,
    parameter logic [W-1:0] BLOCK_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] pend
);

    logic [W-1:0] prev_q;
    logic [W-1:0] hit;
    logic [W-1:0] clr_eff;

    // Event detection: rising edge for edge bits, high level for level bits.
    always_comb begin
        hit     = ((src & ~prev_q & ~LEVEL_MASK) | (src & LEVEL_MASK)) & ~BLOCK_MASK;
        clr_eff = clr_we ? clr_bits : '0;
    end

    // Remember the previous input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src;
    end

    // Pending state: clear requested bits, then set new events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_eff) | hit;
    end

endmodule

// File: rtl/intc2lvl_lowest.sv
// Lowest-set-bit picker: returns a one-hot vector of the lowest set input bit.
// Purely combinational; an all-zero input gives an all-zero output.
module intc2lvl_lowest #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] onehot
);

    logic found;

    // Scan upward and keep the first set bit.
    always_comb begin
        onehot = '0;
        found  = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i] && !found) begin
                onehot[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/intc2lvl_sub_group.sv
// Sub-source grouping: ORs enabled pending sub-sources onto their parent main lines.
// Assumes the fixed parent map in intc2lvl_pkg::parent_of.
module intc2lvl_sub_group
    import intc2lvl_pkg::*;
#(
    parameter int N_MAIN  = 32,
    parameter int SUB_CNT = 11
) (
    input  logic [SUB_CNT-1:0] sub_act,
    output logic [N_MAIN-1:0]  grp_req,
    output logic [N_MAIN-1:0]  grp_used
);

    // Constant set of sub-sources that feed main line m.
    function automatic logic [SUB_CNT-1:0] child_mask(input int m);
        logic [SUB_CNT-1:0] r;
        r = '0;
        for (int s = 0; s < SUB_CNT; s++) r[s] = (parent_of(s) == m);
        return r;
    endfunction

    for (genvar m = 0; m < N_MAIN; m++) begin : g_line
        localparam logic [SUB_CNT-1:0] CMASK = child_mask(m);
        // A line requests while any child is pending and enabled.
        assign grp_req[m]  = |(sub_act & CMASK);
        assign grp_used[m] = |CMASK;
    end

endmodule

// File: rtl/intc2lvl_top.sv
// Two-level interrupt controller top: register port, masks, mode, winner selection.
// Assumes single-cycle register writes and a combinational read path from reg_addr.
module intc2lvl_top
    import intc2lvl_pkg::*;
#(
    parameter int                 N_MAIN     = 32,
    parameter int                 SUB_CNT    = 11,
    parameter int                 DATA_W     = 32,
    parameter logic [N_MAIN-1:0]  MAIN_LEVEL = 32'h9080_8030,
    parameter logic [N_MAIN-1:0]  RESERVED   = 32'h0100_0040,
    parameter logic [SUB_CNT-1:0] SUB_LEVEL  = 11'h1FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_MAIN-1:0]  src_main,
    input  logic [SUB_CNT-1:0] src_sub,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o,
    output logic               fiq_o
);

    reg_sel_e           sel;
    logic [N_MAIN-1:0]  main_pend, main_mask, mode_q, win_q;
    logic [SUB_CNT-1:0] sub_pend, sub_mask, sub_act;
    logic [N_MAIN-1:0]  grp_req, grp_used, main_in;
    logic [N_MAIN-1:0]  cand, pick, mode_pick;

    // Register selection from the byte offset.
    always_comb sel = decode_sel(reg_addr);

    // Enabled pending sub-sources.
    always_comb sub_act = sub_pend & ~sub_mask;

    intc2lvl_sub_group #(.N_MAIN(N_MAIN), .SUB_CNT(SUB_CNT)) u_group (
        .sub_act  (sub_act),
        .grp_req  (grp_req),
        .grp_used (grp_used)
    );

    // Grouped lines take the sub request instead of the external pin.
    always_comb main_in = (src_main & ~grp_used) | grp_req;

    intc2lvl_pend_bank #(
        .W(N_MAIN), .LEVEL_MASK(MAIN_LEVEL | grp_used_const()), .BLOCK_MASK(RESERVED)
    ) u_main_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (main_in),
        .clr_we   (reg_wr && sel == SEL_PEND),
        .clr_bits (reg_wdata[N_MAIN-1:0]),
        .pend     (main_pend)
    );

    intc2lvl_pend_bank #(
        .W(SUB_CNT), .LEVEL_MASK(SUB_LEVEL), .BLOCK_MASK('0)
    ) u_sub_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_sub),
        .clr_we   (reg_wr && sel == SEL_SPEND),
        .clr_bits (reg_wdata[SUB_CNT-1:0]),
        .pend     (sub_pend)
    );

    // Constant set of grouped main lines, so they capture as level.
    function automatic logic [N_MAIN-1:0] grp_used_const();
        logic [N_MAIN-1:0] r;
        r = '0;
        for (int s = 0; s < SUB_CNT; s++) begin
            if (parent_of(s) < N_MAIN) r[parent_of(s)] = 1'b1;
        end
        return r;
    endfunction

    // Winner candidates: pending, unmasked, not routed to the fast line.
    always_comb cand = main_pend & ~main_mask & ~mode_q;

    intc2lvl_lowest #(.W(N_MAIN)) u_pick (.vec(cand), .onehot(pick));
    intc2lvl_lowest #(.W(N_MAIN)) u_mode_pick (.vec(reg_wdata[N_MAIN-1:0]), .onehot(mode_pick));

    // Mask registers: full-value writes, reset to all blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_mask <= '1;
            sub_mask  <= '1;
        end else if (reg_wr) begin
            if (sel == SEL_MASK)  main_mask <= reg_wdata[N_MAIN-1:0];
            if (sel == SEL_SMASK) sub_mask  <= reg_wdata[SUB_CNT-1:0];
        end
    end

    // Mode register keeps only the lowest set bit written.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mode_q <= '0;
        else if (reg_wr && sel == SEL_MODE) mode_q <= mode_pick;
    end

    // Winner register: loads when empty, otherwise write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        win_q <= '0;
        else if (win_q == '0)              win_q <= pick;
        else if (reg_wr && sel == SEL_WIN) win_q <= win_q & ~reg_wdata[N_MAIN-1:0];
    end

    // Request outputs toward the processor.
    always_comb begin
        irq_o = |win_q;
        fiq_o = |(main_pend & ~main_mask & mode_q);
    end

    // Read multiplexer, zero-extended.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_PEND:  reg_rdata[N_MAIN-1:0]  = main_pend;
            SEL_MODE:  reg_rdata[N_MAIN-1:0]  = mode_q;
            SEL_MASK:  reg_rdata[N_MAIN-1:0]  = main_mask;
            SEL_WIN:   reg_rdata[N_MAIN-1:0]  = win_q;
            SEL_SPEND: reg_rdata[SUB_CNT-1:0] = sub_pend;
            SEL_SMASK: reg_rdata[SUB_CNT-1:0] = sub_mask;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intc2lvl_chk.sv
// Property checker for intc2lvl_top, attached by bind below.
// Assumes the default parent map; observes internal registers through the bind.
module intc2lvl_chk
    import intc2lvl_pkg::*;
#(
    parameter int N_MAIN  = 32,
    parameter int SUB_CNT = 11,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [N_MAIN-1:0]  main_pend,
    input logic [N_MAIN-1:0]  main_mask,
    input logic [N_MAIN-1:0]  mode_q,
    input logic [N_MAIN-1:0]  win_q,
    input logic [SUB_CNT-1:0] sub_pend,
    input logic [SUB_CNT-1:0] sub_mask,
    input logic               irq_o,
    input logic               fiq_o
);

    assert_winner_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_q));

    assert_winner_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q != '0 && !(reg_wr && reg_addr == OFS_WIN && (reg_wdata[N_MAIN-1:0] & win_q) != '0))
        |=> win_q == $past(win_q));

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (win_q != '0));

    assert_reserved_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pend[6] && !main_pend[24]);

    assert_group_parent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_pend[0] && !sub_mask[0]) |=> main_pend[parent_of(0)]);

    assert_mode_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_q));

    assert_fiq_needs_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> mode_q != '0);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (&main_mask && &sub_mask && mode_q == '0 && win_q == '0));

endmodule

bind intc2lvl_top intc2lvl_chk #(.N_MAIN(N_MAIN), .SUB_CNT(SUB_CNT), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .main_pend (main_pend),
    .main_mask (main_mask),
    .mode_q    (mode_q),
    .win_q     (win_q),
    .sub_pend  (sub_pend),
    .sub_mask  (sub_mask),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/intc2lvl_top_tb_top.sv
// Self-checking bench: sweeps every main slot and every sub-source, plus selection scenarios.
module intc2lvl_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SUBN       = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     src_main = '0;
    logic [SUBN-1:0] src_sub = '0;
    logic            reg_wr = 1'b0;
    logic [4:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq_o, fiq_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] rv;

    intc2lvl_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_main(src_main), .src_sub(src_sub),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int exp_parent(input int s);
        int grp;
        grp = s / 3;
        if (grp == 0) return 28;
        if (grp == 1) return 23;
        if (grp == 2) return 15;
        return 31;
    endfunction

    function automatic bit is_grouped(input int i);
        return (i == 15 || i == 23 || i == 28 || i == 31);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd(5'h00, rv); check("R1 pend", rv, 32'h0);
        rd(5'h08, rv); check("R1 mask", rv, 32'hFFFF_FFFF);
        rd(5'h04, rv); check("R1 mode", rv, 32'h0);
        rd(5'h10, rv); check("R1 winner", rv, 32'h0);
        rd(5'h18, rv); check("R1 subpend", rv, 32'h0);
        rd(5'h1C, rv); check("R1 submask", rv, 32'h7FF);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 fiq", {31'b0, fiq_o}, 32'h0);
        rd(5'h0C, rv); check("R10 unmapped read", rv, 32'h0);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h08, rv); check("R10 unmapped write", rv, 32'hFFFF_FFFF);

        // R3 R4 R5 R2: sweep every ungrouped main slot with everything masked
        for (int i = 0; i < 32; i++) begin
            if (!is_grouped(i)) begin
                src_main = 32'h1 << i;
                step();
                src_main = '0;
                rd(5'h00, rv);
                check("R3/R5 capture", rv, (i == 6 || i == 24) ? 32'h0 : (32'h1 << i));
                check("R2 masked no irq", {31'b0, irq_o}, 32'h0);
                wr(5'h00, 32'h0);
                rd(5'h00, rv);
                check("R4 write zero", rv, (i == 6 || i == 24) ? 32'h0 : (32'h1 << i));
                wr(5'h00, 32'h1 << i);
                rd(5'h00, rv);
                check("R4 clear", rv, 32'h0);
            end
        end

        // R6 grouped line ignores its external pin
        src_main = 32'h1 << 28;
        step(); step();
        src_main = '0;
        rd(5'h00, rv); check("R6 pin ignored", rv, 32'h0);

        // R3 edge source held high does not re-latch after clear
        src_main = 32'h8;
        step();
        wr(5'h00, 32'h8);
        step();
        rd(5'h00, rv); check("R3 edge no relatch", rv, 32'h0);
        src_main = '0;
        // R3 level source held high re-latches through clear
        src_main = 32'h10;
        step();
        wr(5'h00, 32'h10);
        rd(5'h00, rv); check("R3 level relatch", rv, 32'h10);
        src_main = '0;
        step();
        wr(5'h00, 32'h10);
        rd(5'h00, rv); check("R3 level clear after drop", rv, 32'h0);

        // R7 R8 lowest winner and hand-over
        wr(5'h08, 32'h0);
        src_main = (32'h1 << 10) | (32'h1 << 3);
        step();
        src_main = '0;
        step();
        rd(5'h10, rv); check("R7 lowest wins", rv, 32'h8);
        check("R8 irq high", {31'b0, irq_o}, 32'h1);
        wr(5'h00, 32'h8);
        wr(5'h10, 32'h8);
        check("R8 irq low after ack", {31'b0, irq_o}, 32'h0);
        step();
        rd(5'h10, rv); check("R7 next winner", rv, 32'h1 << 10);
        src_main = 32'h4;
        step();
        src_main = '0;
        step();
        rd(5'h10, rv); check("R7 winner holds", rv, 32'h1 << 10);
        wr(5'h00, 32'h1 << 10);
        wr(5'h10, 32'h1 << 10);
        step();
        rd(5'h10, rv); check("R7 later lower source", rv, 32'h4);
        wr(5'h00, 32'h4);
        wr(5'h10, 32'h4);
        step();
        rd(5'h10, rv); check("R7 empty", rv, 32'h0);
        check("R8 irq idle", {31'b0, irq_o}, 32'h0);

        // R9 fast routing
        wr(5'h04, 32'h0000_5000);
        rd(5'h04, rv); check("R9 mode lowest bit", rv, 32'h1000);
        src_main = 32'h1 << 12;
        step();
        src_main = '0;
        check("R9 fiq high", {31'b0, fiq_o}, 32'h1);
        step();
        rd(5'h10, rv); check("R7 fast source excluded", rv, 32'h0);
        wr(5'h08, 32'h1 << 12);
        check("R2 mask blocks fiq", {31'b0, fiq_o}, 32'h0);
        wr(5'h08, 32'h0);
        wr(5'h04, 32'h0);
        check("R9 fiq low after mode clear", {31'b0, fiq_o}, 32'h0);
        step();
        rd(5'h10, rv); check("R9 back to irq", rv, 32'h1 << 12);
        check("R8 irq after reroute", {31'b0, irq_o}, 32'h1);
        wr(5'h00, 32'h1 << 12);
        wr(5'h10, 32'h1 << 12);
        step();

        // R6 sub-source sweep
        for (int s = 0; s < SUBN; s++) begin
            int p;
            p = exp_parent(s);
            src_sub = SUBN'(1) << s;
            step();
            src_sub = '0;
            rd(5'h18, rv); check("R6 sub capture", rv, 32'h1 << s);
            step();
            rd(5'h00, rv); check("R6 sub masked", rv, 32'h0);
            wr(5'h1C, ~(32'h1 << s) & 32'h7FF);
            step();
            rd(5'h00, rv); check("R6 parent line", rv, 32'h1 << p);
            wr(5'h18, 32'h1 << s);
            wr(5'h00, 32'h1 << p);
            wr(5'h10, 32'h1 << p);
            step();
            rd(5'h10, rv); check("R6 cleanup winner", rv, 32'h0);
            wr(5'h1C, 32'h7FF);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule